// File: doc/BRIEF.md
# Warp Constant Read Serializer

This block serves one constant-memory read request for a whole warp of lanes. Each lane supplies an address and an active bit. The unit finds the distinct addresses among the active lanes and reads each one from a single-ported constant store, one access per cycle. Every value returned is written to all lanes that asked for that address. When all active lanes share one address, a single read serves the whole warp. When the addresses differ, the reads are replayed back to back until every active lane has its data.

On each pass the unit takes the lowest-numbered lane that is still waiting. It reads that lane's address and, in the same pass, completes every waiting lane with the same address. The constant store answers one cycle after the read strobe. When the last value is captured, a single-cycle done pulse comes out together with the full result vector. A running counter adds up the accesses spent beyond the first one of each warp, so it measures the cost of address divergence. A new warp is taken only while the unit is idle.

Top module: `const_read_serializer`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `done_o`, `rd_en_o` and `ser_count_o` are 0.
- R2: When all active lanes carry one address, exactly one read is issued, and `done_o` is high in the cycle after the second clock edge that follows the accepting edge.
- R3: When the active lanes carry k distinct addresses (k ≥ 1), exactly k reads are issued on k consecutive cycles, and `done_o` is high in the cycle after the (k+1)-th clock edge that follows the accepting edge.
- R4: Reads are issued in ascending order of the lowest-numbered active lane that carries each distinct address. No address is read twice within one warp.
- R5: The store returns data on `rd_data_i` one cycle after `rd_en_o`. In the done cycle, lane i of `result_o` (bits i*DATA_W and up) holds the data for that lane's own address, for every active lane.
- R6: Inactive lanes (mask bit 0) are ignored: their addresses are never read, and their slice of `result_o` is 0 in the done cycle. A warp with no active lane issues no read and raises `done_o` with the same timing as k = 1.
- R7: `ser_count_o` adds k−1 for each warp with k ≥ 1 distinct addresses and adds nothing for a warp with no active lane. It changes only at an edge that ends a cycle in which a read was issued.
- R8: `req_ready_o` falls after an accepted request and stays low until the done cycle, in which it is 1 again. A request presented while `req_ready_o` is 0 is ignored and does not change the warp being served.
- R9: `done_o` is high for exactly one cycle per warp. `result_o` changes only at an accept or at a data capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Warp request present |
| req_ready_o | output | 1 | Unit idle; a request is taken at this edge |
| req_mask_i | input | LANES | Active-lane mask, bit i for lane i |
| req_addr_i | input | LANES*ADDR_W | Lane addresses, lane i at bits i*ADDR_W and up |
| rd_en_o | output | 1 | Read strobe to the constant store |
| rd_addr_o | output | ADDR_W | Read address to the constant store |
| rd_data_i | input | DATA_W | Store data, valid one cycle after `rd_en_o` |
| done_o | output | 1 | One-cycle pulse: all active lanes served |
| result_o | output | LANES*DATA_W | Per-lane results, lane i at bits i*DATA_W and up |
| ser_count_o | output | CNT_W | Running count of extra serialized accesses |

## Verification
The bench builds the block with the full 32-lane warp, a 10-bit address and a 16-bit counter. The lane count allows the worst case of 32 distinct addresses, so the longest replay chain and the matching counter step are both tested. The narrow address lets random warps drawn from small address pools produce many duplicate addresses, which exercises uniform, partly shared and fully divergent warps. The counter is wide enough that it does not wrap during the run, so every per-warp increment can be checked exactly.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;

   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_ISSUE = 1'b1
   } csr_state_e;

   localparam int PICK_PREFIX  = 0;
   localparam int PICK_ISOLATE = 1;

endpackage

// File: rtl/csr_lane_pick.sv
`timescale 1ns/1ps
module csr_lane_pick #(
   parameter int LANES      = 32,
   parameter int PICK_STYLE = 0
) (
   input  logic [LANES-1:0] pend_i,
   output logic [LANES-1:0] first_o
);
   import csr_pkg::*;

   generate
      if (PICK_STYLE == PICK_PREFIX) begin : g_prefix
         logic [LANES-1:0] below;
         assign below[0] = 1'b0;
         for (genvar i = 1; i < LANES; i++) begin : g_chain
            assign below[i] = below[i-1] | pend_i[i-1];
         end
         assign first_o = pend_i & ~below;
      end else begin : g_isolate
         assign first_o = pend_i & (~pend_i + {{(LANES-1){1'b0}}, 1'b1});
      end
   endgenerate

endmodule

// File: rtl/csr_addr_match.sv
`timescale 1ns/1ps
module csr_addr_match #(
   parameter int LANES  = 32,
   parameter int ADDR_W = 10
) (
   input  logic [LANES*ADDR_W-1:0] addr_i,
   input  logic [LANES-1:0]        pend_i,
   input  logic [LANES-1:0]        sel_i,
   output logic [ADDR_W-1:0]       key_o,
   output logic [LANES-1:0]        hit_o
);

   always_comb begin
      key_o = '0;
      for (int i = 0; i < LANES; i++) begin
         if (sel_i[i]) key_o = key_o | addr_i[i*ADDR_W +: ADDR_W];
      end
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_cmp
         assign hit_o[i] = pend_i[i] && (addr_i[i*ADDR_W +: ADDR_W] == key_o);
      end
   endgenerate

endmodule

// File: rtl/csr_result_bank.sv
`timescale 1ns/1ps
module csr_result_bank #(
   parameter int LANES  = 32,
   parameter int DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic [LANES-1:0]        wr_mask_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   output logic [LANES*DATA_W-1:0] result_o
);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            val_q <= '0;
            else if (clr_i)        val_q <= '0;
            else if (wr_mask_i[i]) val_q <= wr_data_i;
         end
         assign result_o[i*DATA_W +: DATA_W] = val_q;
      end
   endgenerate

endmodule

// File: rtl/const_read_serializer.sv
`timescale 1ns/1ps
module const_read_serializer #(
   parameter int LANES      = 32,
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int PICK_STYLE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid_i,
   output logic                    req_ready_o,
   input  logic [LANES-1:0]        req_mask_i,
   input  logic [LANES*ADDR_W-1:0] req_addr_i,
   output logic                    rd_en_o,
   output logic [ADDR_W-1:0]       rd_addr_o,
   input  logic [DATA_W-1:0]       rd_data_i,
   output logic                    done_o,
   output logic [LANES*DATA_W-1:0] result_o,
   output logic [CNT_W-1:0]        ser_count_o
);
   import csr_pkg::*;

   localparam int ADDR_BITS = LANES * ADDR_W;
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("LANES must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
      if (PICK_STYLE != PICK_PREFIX && PICK_STYLE != PICK_ISOLATE) begin : g_bad_pick
         $error("PICK_STYLE out of range");
      end
   endgenerate

   csr_state_e             st_q;
   logic [ADDR_BITS-1:0]   addr_q;
   logic [LANES-1:0]       pend_q;
   logic [LANES-1:0]       hit_q;
   logic                   last_q;
   logic                   done_q;
   logic                   first_q;
   logic [CNT_W-1:0]       cnt_q;

   logic [LANES-1:0]       sel;
   logic [LANES-1:0]       match;
   logic [LANES-1:0]       rest;
   logic [ADDR_W-1:0]      key;
   logic                   accept;
   logic                   issuing;
   logic                   finishing;

   csr_lane_pick #(
      .LANES      (LANES),
      .PICK_STYLE (PICK_STYLE)
   ) u_pick (
      .pend_i  (pend_q),
      .first_o (sel)
   );

   csr_addr_match #(
      .LANES  (LANES),
      .ADDR_W (ADDR_W)
   ) u_match (
      .addr_i (addr_q),
      .pend_i (pend_q),
      .sel_i  (sel),
      .key_o  (key),
      .hit_o  (match)
   );

   assign req_ready_o = (st_q == ST_IDLE) && !last_q;
   assign accept      = req_valid_i && req_ready_o;
   assign rest        = pend_q & ~match;
   assign issuing     = (st_q == ST_ISSUE) && (|pend_q);
   assign finishing   = (st_q == ST_ISSUE) && (rest == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         pend_q  <= '0;
         hit_q   <= '0;
         last_q  <= 1'b0;
         done_q  <= 1'b0;
         first_q <= 1'b0;
      end else begin
         hit_q  <= issuing ? match : '0;
         last_q <= finishing;
         done_q <= last_q;
         if (accept) begin
            st_q    <= ST_ISSUE;
            addr_q  <= req_addr_i;
            pend_q  <= req_mask_i;
            first_q <= 1'b1;
         end else if (st_q == ST_ISSUE) begin
            pend_q <= rest;
            if (issuing) first_q <= 1'b0;
            if (finishing) st_q <= ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (issuing && !first_q) cnt_q <= cnt_q + CNT_ONE;
   end

   csr_result_bank #(
      .LANES  (LANES),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (accept),
      .wr_mask_i (hit_q),
      .wr_data_i (rd_data_i),
      .result_o  (result_o)
   );

   assign rd_en_o     = issuing;
   assign rd_addr_o   = key;
   assign done_o      = done_q;
   assign ser_count_o = cnt_q;

endmodule

// File: rtl/csr_checker.sv
`timescale 1ns/1ps
module csr_checker #(
   parameter int LANES  = 32,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid_i,
   input logic                    req_ready_o,
   input logic                    rd_en_o,
   input logic                    done_o,
   input logic [LANES*DATA_W-1:0] result_o,
   input logic [CNT_W-1:0]        ser_count_o
);

   AST_NO_READ_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> !req_ready_o); // R8
   AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o) |=> !req_ready_o); // R8
   AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> req_ready_o); // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_COUNT_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_o |=> $stable(ser_count_o)); // R7
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rd_en_o) && !(req_valid_i && req_ready_o)) |=> $stable(result_o)); // R9

endmodule

bind const_read_serializer csr_checker #(
   .LANES  (LANES),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid_i (req_valid_i),
   .req_ready_o (req_ready_o),
   .rd_en_o     (rd_en_o),
   .done_o      (done_o),
   .result_o    (result_o),
   .ser_count_o (ser_count_o)
);

// File: tb/tb_const_read_serializer.sv
`timescale 1ns/1ps
module tb_const_read_serializer;
   localparam int LANES  = 32;
   localparam int ADDR_W = 10;
   localparam int DATA_W = 32;
   localparam int CNT_W  = 16;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    req_valid_i = 1'b0;
   logic                    req_ready_o;
   logic [LANES-1:0]        req_mask_i = '0;
   logic [LANES*ADDR_W-1:0] req_addr_i = '0;
   logic                    rd_en_o;
   logic [ADDR_W-1:0]       rd_addr_o;
   logic [DATA_W-1:0]       rd_data_i = '0;
   logic                    done_o;
   logic [LANES*DATA_W-1:0] result_o;
   logic [CNT_W-1:0]        ser_count_o;

   int checks = 0;
   int failures = 0;
   logic [ADDR_W-1:0] rlog [4096];
   int nlog = 0;
   logic [CNT_W-1:0] exp_cnt = '0;
   logic [ADDR_W-1:0] wa [LANES];
   logic [LANES-1:0]  wm;

   always #10 clk = ~clk;

   const_read_serializer #(
      .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PICK_STYLE(0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
      .req_mask_i(req_mask_i), .req_addr_i(req_addr_i), .rd_en_o(rd_en_o),
      .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .done_o(done_o),
      .result_o(result_o), .ser_count_o(ser_count_o)
   );

   function automatic logic [DATA_W-1:0] store_val(input logic [ADDR_W-1:0] a);
      return ({22'd0, a} * 32'h9E3779B1) ^ 32'h00A5_5A5A;
   endfunction

   // constant store model, one-cycle read latency (R5)
   always @(posedge clk) if (rd_en_o) rd_data_i <= store_val(rd_addr_o);
   always @(negedge clk) if (rd_en_o) begin
      if (nlog < 4096) rlog[nlog] = rd_addr_o;
      nlog++;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_warp();
      logic [ADDR_W-1:0] uq [LANES];
      int nu = 0;
      int lat;
      int cyc = 0;
      int start;
      bit hung = 0;
      bit res_ok = 1;
      bit zero_ok = 1;
      bit seq_ok = 1;
      for (int l = 0; l < LANES; l++) begin
         bit seen = 0;
         if (!wm[l]) continue;
         for (int u = 0; u < nu; u++) if (uq[u] == wa[l]) seen = 1;
         if (!seen) begin uq[nu] = wa[l]; nu++; end
      end
      lat = (nu == 0) ? 2 : nu + 1;
      @(negedge clk);
      while (!req_ready_o) @(negedge clk);
      start = nlog;
      req_valid_i = 1'b1;
      req_mask_i  = wm;
      for (int l = 0; l < LANES; l++) req_addr_i[l*ADDR_W +: ADDR_W] = wa[l];
      @(negedge clk);
      req_valid_i = 1'b0;
      while (!done_o) begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) begin
            check(req_ready_o == 1'b0, "R8 ready low while busy", req_ready_o, 0);
            req_valid_i = 1'b1;
            req_mask_i  = ~wm;
            req_addr_i  = {LANES{10'h3FF}};
         end else if (cyc == 2) begin
            req_valid_i = 1'b0;
         end
         if (cyc > 200) begin hung = 1; break; end
      end
      req_valid_i = 1'b0;
      check(!hung, "R3 watchdog: done never came", cyc, lat);
      if (hung) return;
      check(cyc == lat, nu == 1 ? "R2 uniform latency" : (nu == 0 ? "R6 empty-mask latency" : "R3 divergent latency"), cyc, lat);
      check(req_ready_o == 1'b1, "R8 ready in done cycle", req_ready_o, 1);
      check(nlog - start == nu, nu == 1 ? "R2 single read" : "R3 read count", nlog - start, nu);
      for (int u = 0; u < nu && u < nlog - start; u++)
         if (rlog[(start + u) % 4096] != uq[u]) seq_ok = 0;
      check(seq_ok, "R4 read order", nlog - start, nu);
      for (int l = 0; l < LANES; l++) begin
         logic [DATA_W-1:0] got = result_o[l*DATA_W +: DATA_W];
         if (wm[l] && got != store_val(wa[l])) begin
            res_ok = 0;
            $display("FAIL R5 lane %0d actual=%0h expected=%0h", l, got, store_val(wa[l]));
         end
         if (!wm[l] && got != '0) zero_ok = 0;
      end
      check(res_ok, "R5 lane results", 0, 0);
      check(zero_ok, "R6 inactive lanes zero", 0, 0);
      if (nu > 0) exp_cnt = exp_cnt + CNT_W'(nu - 1);
      check(ser_count_o == exp_cnt, "R7 serialization count", ser_count_o, exp_cnt);
      @(negedge clk);
      check(done_o == 1'b0, "R9 done single cycle", done_o, 0);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready_o == 1'b1, "R1 reset ready", req_ready_o, 1);
      check(done_o == 1'b0, "R1 reset done", done_o, 0);
      check(rd_en_o == 1'b0, "R1 reset rd_en", rd_en_o, 0);
      check(ser_count_o == '0, "R1 reset count", ser_count_o, 0);

      // R2 uniform, all lanes
      wm = '1; for (int l = 0; l < LANES; l++) wa[l] = 10'h05A;
      run_warp();
      // R3 fully divergent
      wm = '1; for (int l = 0; l < LANES; l++) wa[l] = ADDR_W'(LANES - l);
      run_warp();
      // R6 no active lane
      wm = '0; for (int l = 0; l < LANES; l++) wa[l] = ADDR_W'(l);
      run_warp();
      // R6 single top lane, others differ
      wm = 32'h8000_0000; for (int l = 0; l < LANES; l++) wa[l] = ADDR_W'(l * 7);
      run_warp();
      // R4 alternating pair, lane 0 inactive
      wm = 32'hFFFF_FFFE; for (int l = 0; l < LANES; l++) wa[l] = (l % 2) ? 10'h111 : 10'h222;
      run_warp();
      // random warps from small address pools
      for (int t = 0; t < 60; t++) begin
         int pool = 1 + ($urandom % 8);
         logic [ADDR_W-1:0] base = ADDR_W'($urandom);
         case ($urandom % 3)
            0: wm = '1;
            default: wm = $urandom;
         endcase
         for (int l = 0; l < LANES; l++) wa[l] = base + ADDR_W'(($urandom % pool) * 3);
         run_warp();
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule